// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between the internal transmit-enable request of a 10 Mb/s twisted-pair transmitter and the line drivers. It cuts off a transmitter that keeps transmitting past the legal frame length. While the request stays high, an activity timer counts time-base ticks. If the request holds for the full trip limit, the block enters a lockout state. In that state the gated transmit enable is forced low and a status flag is raised.

The lockout does not end when the request drops. The request must first stay low without a break for a long recovery window, the unjab time, and only then are the outputs enabled again. Any reassertion during that window keeps the lockout in force and starts the window over.

The guard works only when the 10BASE-T mode select is high. In any other mode the request passes straight to the output and neither timer runs. Both limits are parameters counted in ticks of an external single-cycle time base. With a 1 µs tick, the defaults give 25 ms to trip and 500 ms to recover.

Top module: `jabber_watchdog`

## Requirements
- R1: After reset, `jabber` is 0, both timers are zero, and `tx_en_out` follows `tx_req`.
- R2: In 10BASE-T mode, when `tx_req` stays high for TRIP_TICKS ticks in a row, the block trips on the clock edge that registers the last of those ticks. From the next cycle, `tx_en_out` is 0 and `jabber` is 1.
- R3: If `tx_req` falls before the trip limit is reached, the activity count restarts from zero. A later burst then needs a full TRIP_TICKS ticks to trip.
- R4: Once tripped, the block stays locked with `tx_en_out` at 0 for as long as `tx_req` stays high, however many ticks pass.
- R5: The block releases on the edge that registers the UNJAB_TICKS-th tick with `tx_req` continuously low. `jabber` returns to 0, and from then on `tx_en_out` follows `tx_req`.
- R6: If `tx_req` rises while the unjab window is running, the window restarts from zero and the lockout continues.
- R7: When `mode_10bt` is 0, `tx_en_out` equals `tx_req` in the same cycle and no timer advances. A clock edge with `mode_10bt` low clears any lockout.
- R8: Both timers advance only in cycles where `tick` is high. Without ticks, no trip and no release happen, however long the request is held.
- R9: `jabber` is high from the trip until the unjab window completes, and at no other time.
- R10: When not locked, `tx_en_out` is a same-cycle copy of `tx_req`, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Internal transmit-enable request |
| mode_10bt | input | 1 | High selects 10BASE-T operation, which enables the guard |
| tick | input | 1 | Single-cycle time-base pulse that advances the timers |
| tx_en_out | output | 1 | Gated transmit enable to the drivers |
| jabber | output | 1 | High while the transmitter is locked out |

## Verification
The bench targets the exact tick on which the trip happens. A count that is one tick off would trip early or late. A design that never cleared the activity count on a short idle would trip on the second of two short bursts.

During lockout, the bench holds the request high well past the unjab length. A design that released on a timer alone would turn the output back on. It also breaks the unjab window with a one-cycle request pulse. A design that did not restart the window would release early.

Finally, the bench holds the request for a long time with no ticks, runs in non-10BASE-T mode, and leaves that mode mid-lockout. These catch timers that run free, a guard that acts in the wrong mode, and a lockout that survives a mode change.

// File: rtl/jabber_pkg.sv
package jabber_pkg;

    typedef enum logic [0:0] {
        JS_ARMED  = 1'b0,
        JS_LOCKED = 1'b1
    } jab_state_e;

    typedef struct packed {
        jab_state_e state;
    } ctrl_regs_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/jab_tick_counter.sv
module jab_tick_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic hit
);
    import jabber_pkg::*;

    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        hit = 1'b0;
        if (clear) begin
            r_d.cnt = '0;
        end else if (step) begin
            if (r_q.cnt == LAST) begin
                hit     = 1'b1;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/jab_ctrl.sv
module jab_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic mode_10bt,
    input  logic tick,
    input  logic act_hit,
    input  logic idle_hit,
    output logic act_clear,
    output logic act_step,
    output logic idle_clear,
    output logic idle_step,
    output logic locked,
    output logic tx_gated
);
    import jabber_pkg::*;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        act_clear  = 1'b1;
        act_step   = 1'b0;
        idle_clear = 1'b1;
        idle_step  = 1'b0;
        if (!mode_10bt) begin
            r_d.state = JS_ARMED;
        end else begin
            unique case (r_q.state)
                JS_ARMED: begin
                    act_clear = !tx_req;
                    act_step  = tx_req && tick;
                    if (act_hit) begin
                        r_d.state = JS_LOCKED;
                    end
                end
                JS_LOCKED: begin
                    idle_clear = tx_req;
                    idle_step  = !tx_req && tick;
                    if (idle_hit) begin
                        r_d.state = JS_ARMED;
                    end
                end
                default: r_d.state = JS_ARMED;
            endcase
        end
    end

    assign locked   = (r_q.state == JS_LOCKED);
    assign tx_gated = tx_req && (!locked || !mode_10bt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: JS_ARMED};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/jabber_watchdog.sv
module jabber_watchdog #(
    parameter int unsigned TRIP_TICKS  = 25000,
    parameter int unsigned UNJAB_TICKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic mode_10bt,
    input  logic tick,
    output logic tx_en_out,
    output logic jabber
);

    logic act_clear, act_step, act_hit;
    logic idle_clear, idle_step, idle_hit;

    jab_tick_counter #(.LIMIT(TRIP_TICKS)) u_active (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (act_clear),
        .step  (act_step),
        .hit   (act_hit)
    );

    jab_tick_counter #(.LIMIT(UNJAB_TICKS)) u_unjab (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idle_clear),
        .step  (idle_step),
        .hit   (idle_hit)
    );

    jab_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_req     (tx_req),
        .mode_10bt  (mode_10bt),
        .tick       (tick),
        .act_hit    (act_hit),
        .idle_hit   (idle_hit),
        .act_clear  (act_clear),
        .act_step   (act_step),
        .idle_clear (idle_clear),
        .idle_step  (idle_step),
        .locked     (jabber),
        .tx_gated   (tx_en_out)
    );

endmodule

// File: rtl/jabber_watchdog_checker.sv
module jabber_watchdog_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_req,
    input logic mode_10bt,
    input logic tick,
    input logic tx_en_out,
    input logic jabber
);

    // R2: locked in 10BASE-T mode means the drivers are off
    a_r2_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
        (jabber && mode_10bt) |-> !tx_en_out);

    // R4: request held during lockout keeps the lockout
    a_r4_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (jabber && tx_req && mode_10bt) |=> jabber);

    // R7: other modes pass the request straight through
    a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10bt |-> (tx_en_out == tx_req));

    // R8: no tick, no release
    a_r8_no_release_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (jabber && !tick && mode_10bt) |=> jabber);

    // R8: no tick, no trip
    a_r8_no_trip_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!jabber && !tick) |=> !jabber);

    // R9: a trip follows a ticked, requested, 10BASE-T cycle
    a_r9_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jabber) |-> ($past(tx_req) && $past(tick) && $past(mode_10bt)));

    // R5: a release in 10BASE-T mode follows an idle ticked cycle
    a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(jabber) && $past(mode_10bt)) |-> (!$past(tx_req) && $past(tick)));

    // R10: when unlocked the output copies the request
    a_r10_unlocked_copy: assert property (@(posedge clk) disable iff (!rst_n)
        !jabber |-> (tx_en_out == tx_req));

endmodule

bind jabber_watchdog jabber_watchdog_checker u_jabber_watchdog_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .mode_10bt (mode_10bt),
    .tick      (tick),
    .tx_en_out (tx_en_out),
    .jabber    (jabber)
);

// File: tb/jabber_watchdog_bench.sv
module jabber_watchdog_bench;

    localparam int unsigned TRIP  = 5;
    localparam int unsigned UNJAB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_req = 1'b0;
    logic mode_10bt = 1'b1;
    logic tick = 1'b0;
    logic tx_en_out;
    logic jabber;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    jabber_watchdog #(.TRIP_TICKS(TRIP), .UNJAB_TICKS(UNJAB)) u_jabber_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_req    (tx_req),
        .mode_10bt (mode_10bt),
        .tick      (tick),
        .tx_en_out (tx_en_out),
        .jabber    (jabber)
    );

    task automatic check(input string req, input logic exp_en, input logic exp_jab);
        n_checks++;
        if (tx_en_out !== exp_en || jabber !== exp_jab) begin
            n_fail++;
            $display("FAIL %s: tx_en_out=%b jabber=%b expected tx_en_out=%b jabber=%b",
                     req, tx_en_out, jabber, exp_en, exp_jab);
        end
    endtask

    // one tick registered at a posedge, then outputs sampled mid-cycle
    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
        #1;
    endtask

    task automatic set_req(input logic v);
        @(negedge clk); tx_req = v; #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; tx_req = 1'b0; tick = 1'b0; mode_10bt = 1'b1;
        @(negedge clk); @(negedge clk); rst_n = 1'b1; #1;
    endtask

    task automatic trip_now();
        set_req(1'b1);
        pulse_ticks(TRIP);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset idle", 1'b0, 1'b0);
        set_req(1'b1);
        check("R1 request passes after reset", 1'b1, 1'b0);
        set_req(1'b0);
    endtask

    task automatic t_trip_and_restart();
        do_reset();
        set_req(1'b1);
        check("R10 same-cycle copy", 1'b1, 1'b0);
        pulse_ticks(TRIP - 1);
        check("R2 no trip one tick short", 1'b1, 1'b0);
        set_req(1'b0);
        pulse_ticks(2);
        set_req(1'b1);
        pulse_ticks(TRIP - 1);
        check("R3 count restarted after short frame", 1'b1, 1'b0);
        pulse_ticks(1);
        check("R2 trip on the limit tick", 1'b0, 1'b1);
    endtask

    task automatic t_hold_and_unjab();
        do_reset();
        trip_now();
        pulse_ticks(UNJAB + 3);
        check("R4 lockout holds while requested", 1'b0, 1'b1);
        set_req(1'b0);
        pulse_ticks(UNJAB - 1);
        check("R9 still jabbing one tick before release", 1'b0, 1'b1);
        set_req(1'b1);
        check("R6 request during unjab stays gated", 1'b0, 1'b1);
        set_req(1'b0);
        pulse_ticks(UNJAB - 1);
        check("R6 unjab window restarted", 1'b0, 1'b1);
        pulse_ticks(1);
        check("R5 release after full idle window", 1'b0, 1'b0);
        set_req(1'b1);
        check("R5 output follows request after release", 1'b1, 1'b0);
        set_req(1'b0);
    endtask

    task automatic t_no_tick();
        do_reset();
        set_req(1'b1);
        repeat (60) @(negedge clk);
        #1;
        check("R8 no trip without ticks", 1'b1, 1'b0);
        pulse_ticks(TRIP);
        set_req(1'b0);
        repeat (60) @(negedge clk);
        #1;
        check("R8 no release without ticks", 1'b0, 1'b1);
    endtask

    task automatic t_other_mode();
        do_reset();
        @(negedge clk); mode_10bt = 1'b0;
        set_req(1'b1);
        pulse_ticks(TRIP * 3);
        check("R7 no trip outside 10BASE-T", 1'b1, 1'b0);
        @(negedge clk); mode_10bt = 1'b1; #1;
        pulse_ticks(TRIP - 1);
        check("R7 no ticks counted while mode was off", 1'b1, 1'b0);
        pulse_ticks(1);
        check("R2 trip after mode back on", 1'b0, 1'b1);
        @(negedge clk); mode_10bt = 1'b0; #1;
        check("R7 passthrough same cycle on mode change", 1'b1, 1'b1);
        @(negedge clk); #1;
        check("R7 mode change clears lockout", 1'b1, 1'b0);
        set_req(1'b0);
    endtask

    task automatic t_reset_mid_lock();
        do_reset();
        trip_now();
        check("R2 locked before reset", 1'b0, 1'b1);
        do_reset();
        set_req(1'b1);
        check("R1 reset clears lockout", 1'b1, 1'b0);
        pulse_ticks(TRIP - 1);
        check("R1 reset cleared the active count", 1'b1, 1'b0);
        set_req(1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_trip_and_restart();
        t_hold_and_unjab();
        t_no_tick();
        t_other_mode();
        t_reset_mid_lock();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule